// File: doc/BRIEF.md
# Auxiliary Event Timestamp Capture

This block records the current system time when an external event occurs. It has two independent capture channels: channel 0 serves the master role and channel 1 the slave role. Each channel has its own trigger input. The trigger may come from software (through a general-purpose output looped back) or from an external device. Each trigger is synchronised to the block clock with a flop chain. Only its rising edge is acted on.

On a capture, the channel's snapshot register loads the system time and the channel's sticky event flag sets. The channel's interrupt output is raised only when its enable bit is set in the mask register. With the enable bit clear, software polls the flag instead. A second capture that arrives while the flag is still set replaces the snapshot with the newer time and sets the channel's overflow bit. Software clears the flag and the overflow bit by writing a one to the channel's clear bit.

The block has two resets. A power-on reset and a synchronous software reset both return it to the same state, with both interrupts disabled.

Top module: `aux_stamp_capture`

## Requirements
- R1: After `rst_n` is low, or `sw_rst` is high for one clock edge, all of the following are zero and `irq_master`/`irq_slave` are low:
  - both snapshots
  - `evt_flag`
  - `ovf_flag`
  - `mask_q`
- R2: Bit 0 of `trig_in` is the master trigger (`snap_master`) and bit 1 is the slave trigger (`snap_slave`). For a trigger that first reads high at clock edge k, the snapshot, the flag and the overflow bit are updated at edge k+2. The snapshot takes the `sys_time` value sampled at that edge.
- R3: A capture occurs only on a rising edge of the synchronised trigger. A trigger held high for many cycles gives one capture. A falling trigger changes nothing.
- R4: `evt_flag[i]` is sticky. It is cleared, together with `ovf_flag[i]`, by `flag_clr[i]` being high at a clock edge. A zero in `flag_clr` has no effect.
- R5: `irq_master` is high exactly when `evt_flag[0]` and `mask_q[0]` are both set. `irq_slave` is high exactly when `evt_flag[1]` and `mask_q[1]` are both set. With the enable bit clear, a capture only sets the flag.
- R6: When `mask_we` is high at a clock edge, `mask_q` loads `mask_wdata`. Bit 0 enables the master interrupt and bit 1 enables the slave interrupt.
- R7: A capture while `evt_flag[i]` is already set overwrites the snapshot with the newer time and sets `ovf_flag[i]`. A capture with the flag clear leaves `ovf_flag[i]` clear.
- R8: The channels are independent. A capture, a clear or an enable on one channel does not alter the other channel's snapshot, flag, overflow bit or interrupt. Captures on both channels in the same cycle are both recorded.
- R9: When a capture and a clear of the same channel fall on the same clock edge, the capture wins. The flag stays set, and the overflow bit is set if the flag was set before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sw_rst | input | 1 | Synchronous software reset, active high |
| sys_time | input | TIME_W | Current system time |
| trig_in | input | 2 | Asynchronous triggers (bit 0 master, bit 1 slave) |
| mask_we | input | 1 | Write strobe for the interrupt enable register |
| mask_wdata | input | 2 | New interrupt enable bits |
| flag_clr | input | 2 | Write-one-to-clear for the event and overflow bits |
| mask_q | output | 2 | Current interrupt enable bits |
| snap_master | output | TIME_W | Master channel snapshot |
| snap_slave | output | TIME_W | Slave channel snapshot |
| evt_flag | output | 2 | Sticky capture event flags |
| ovf_flag | output | 2 | Overwrite-while-pending flags |
| irq_master | output | 1 | Master capture interrupt |
| irq_slave | output | 1 | Slave capture interrupt |

## Verification
Some properties are checked on every cycle:
- a disabled channel never raises its interrupt, and an interrupt is never raised without a pending flag;
- an overflow bit only rises when its flag was already set, and never stands without the flag;
- a flag only falls after a clear or a software reset;
- a software reset leaves the flags, the overflow bits and the enables at zero.

Other behaviour needs the bench's scenarios:
- the exact capture latency and the captured time value;
- a single capture for a long trigger pulse;
- independence of the two channels;
- the capture-wins rule when a capture and a clear meet on the same edge.

// File: rtl/aux_stamp_pkg.sv
package aux_stamp_pkg;
   localparam int NUM_CH    = 2;
   localparam int CH_MASTER = 0;
   localparam int CH_SLAVE  = 1;

   typedef logic [NUM_CH-1:0] ch_vec_t;
endpackage

// File: rtl/aux_sync.sv
module aux_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] stage_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("aux_sync: STAGES must be at least 2");
      end
   endgenerate

   // first stage samples the asynchronous input
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[0] <= 1'b0;
      else if (sw_rst) stage_q[0] <= 1'b0;
      else             stage_q[0] <= din;
   end

   // remaining stages form the settling chain
   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage_q[s] <= 1'b0;
            else if (sw_rst) stage_q[s] <= 1'b0;
            else             stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/aux_rise.sv
module aux_rise (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst,
   input  logic lvl,
   output logic hit
);
   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_d <= 1'b0;
      else if (sw_rst) lvl_d <= 1'b0;
      else             lvl_d <= lvl;
   end

   assign hit = lvl & ~lvl_d;
endmodule

// File: rtl/aux_chan.sv
module aux_chan #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              hit,
   input  logic              clr,
   input  logic              irq_on,
   input  logic [TIME_W-1:0] now,
   output logic [TIME_W-1:0] snap,
   output logic              pend,
   output logic              lost,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap <= '0;
         pend <= 1'b0;
         lost <= 1'b0;
      end else if (sw_rst) begin
         snap <= '0;
         pend <= 1'b0;
         lost <= 1'b0;
      end else if (hit) begin
         // capture has priority over a clear on the same edge
         snap <= now;
         pend <= 1'b1;
         lost <= lost | pend;
      end else if (clr) begin
         pend <= 1'b0;
         lost <= 1'b0;
      end
   end

   assign irq = pend & irq_on;
endmodule

// File: rtl/aux_stamp_capture.sv
module aux_stamp_capture
   import aux_stamp_pkg::*;
#(
   parameter int TIME_W      = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic [TIME_W-1:0] sys_time,
   input  logic [1:0]        trig_in,
   input  logic              mask_we,
   input  logic [1:0]        mask_wdata,
   input  logic [1:0]        flag_clr,
   output logic [1:0]        mask_q,
   output logic [TIME_W-1:0] snap_master,
   output logic [TIME_W-1:0] snap_slave,
   output logic [1:0]        evt_flag,
   output logic [1:0]        ovf_flag,
   output logic              irq_master,
   output logic              irq_slave
);
   generate
      if (TIME_W < 1) begin : g_bad_width
         $error("aux_stamp_capture: TIME_W must be positive");
      end
      if (NUM_CH != 2) begin : g_bad_count
         $error("aux_stamp_capture: exactly two channels are supported");
      end
   endgenerate

   logic [TIME_W-1:0] snap_v [NUM_CH];
   ch_vec_t           trig_s;
   ch_vec_t           hit_v;
   ch_vec_t           irq_v;

   // interrupt enables, both off after either reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (sw_rst)  mask_q <= '0;
      else if (mask_we) mask_q <= mask_wdata;
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         aux_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_rst (sw_rst),
            .din    (trig_in[c]),
            .dout   (trig_s[c])
         );

         aux_rise u_rise (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_rst (sw_rst),
            .lvl    (trig_s[c]),
            .hit    (hit_v[c])
         );

         aux_chan #(.TIME_W(TIME_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_rst (sw_rst),
            .hit    (hit_v[c]),
            .clr    (flag_clr[c]),
            .irq_on (mask_q[c]),
            .now    (sys_time),
            .snap   (snap_v[c]),
            .pend   (evt_flag[c]),
            .lost   (ovf_flag[c]),
            .irq    (irq_v[c])
         );
      end
   endgenerate

   assign snap_master = snap_v[CH_MASTER];
   assign snap_slave  = snap_v[CH_SLAVE];
   assign irq_master  = irq_v[CH_MASTER];
   assign irq_slave   = irq_v[CH_SLAVE];
endmodule

// File: rtl/aux_stamp_chk.sv
module aux_stamp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sw_rst,
   input logic [1:0] flag_clr,
   input logic [1:0] mask_q,
   input logic [1:0] evt_flag,
   input logic [1:0] ovf_flag,
   input logic       irq_master,
   input logic       irq_slave
);
   logic [1:0] irq_all;
   assign irq_all = {irq_slave, irq_master};

   // R1
   swrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> (mask_q == 2'b00) && (evt_flag == 2'b00) && (ovf_flag == 2'b00));

   generate
      for (genvar c = 0; c < 2; c++) begin : g_chk
         // R5
         masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mask_q[c] |-> !irq_all[c]);

         // R5
         irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_all[c] |-> evt_flag[c]);

         // R7
         ovf_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_flag[c]) |-> $past(evt_flag[c]));

         // R7
         ovf_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_flag[c] |-> evt_flag[c]);

         // R4
         flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(evt_flag[c]) |-> ($past(flag_clr[c]) || $past(sw_rst)));
      end
   endgenerate
endmodule

bind aux_stamp_capture aux_stamp_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_rst     (sw_rst),
   .flag_clr   (flag_clr),
   .mask_q     (mask_q),
   .evt_flag   (evt_flag),
   .ovf_flag   (ovf_flag),
   .irq_master (irq_master),
   .irq_slave  (irq_slave)
);

// File: tb/aux_stamp_capture_test.sv
`timescale 1ns/1ps
module aux_stamp_capture_test;
   localparam int TW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_rst = 1'b0;
   logic [TW-1:0] sys_time = 64'd1000;
   logic [1:0]    trig_in = 2'b00;
   logic          mask_we = 1'b0;
   logic [1:0]    mask_wdata = 2'b00;
   logic [1:0]    flag_clr = 2'b00;
   logic [1:0]    mask_q;
   logic [TW-1:0] snap_master, snap_slave;
   logic [1:0]    evt_flag, ovf_flag;
   logic          irq_master, irq_slave;

   aux_stamp_capture #(.TIME_W(TW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .sys_time(sys_time),
      .trig_in(trig_in), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .flag_clr(flag_clr), .mask_q(mask_q), .snap_master(snap_master),
      .snap_slave(snap_slave), .evt_flag(evt_flag), .ovf_flag(ovf_flag),
      .irq_master(irq_master), .irq_slave(irq_slave));

   always #5 clk = ~clk;

   longint cyc = 0;
   always @(posedge clk) begin
      cyc      <= cyc + 1;
      sys_time <= sys_time + 64'd1;
   end

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit quiet  = 1'b1;

   typedef struct {
      int            ch;
      logic [TW-1:0] t;
      longint        at;
   } exp_t;
   exp_t q[$];

   logic [1:0]    m_flag = 2'b00;
   logic [1:0]    m_ovf  = 2'b00;
   logic [1:0]    m_mask = 2'b00;
   logic [TW-1:0] last_snap [2];

   task automatic check(input bit ok, input string tag, input logic [TW-1:0] act,
                        input logic [TW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: every snapshot change must match the oldest pending expectation
   always @(negedge clk) begin
      if (quiet) begin
         last_snap[0] = snap_master;
         last_snap[1] = snap_slave;
      end else begin
         for (int c = 0; c < 2; c++) begin
            logic [TW-1:0] s;
            s = (c == 0) ? snap_master : snap_slave;
            if (s != last_snap[c]) begin
               last_snap[c] = s;
               if (q.size() == 0) begin
                  check(1'b0, "R3 unexpected capture", s, 0);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  check(e.ch == c, "R8 capture channel", c, e.ch);
                  check(s == e.t, "R2 captured time", s, e.t);
                  check(cyc == e.at, "R2 capture cycle", cyc, e.at);
                  m_ovf[c]  = m_ovf[c] | m_flag[c];
                  m_flag[c] = 1'b1;
                  check(evt_flag[c] == 1'b1, "R4 flag set on capture", evt_flag[c], 1);
                  check(ovf_flag[c] == m_ovf[c], "R7 overflow bit", ovf_flag[c], m_ovf[c]);
                  check({irq_slave, irq_master}[c] == m_mask[c], "R5 irq on capture",
                        {irq_slave, irq_master}[c], m_mask[c]);
               end
            end
         end
      end
   end

   // driver: raise a trigger for w cycles and predict the capture
   task automatic pulse(input logic [1:0] chs, input int w);
      @(negedge clk);
      trig_in = chs;
      for (int c = 0; c < 2; c++)
         if (chs[c]) q.push_back('{ch: c, t: sys_time + 64'd2, at: cyc + 3});
      repeat (w) @(negedge clk);
      trig_in = 2'b00;
   endtask

   task automatic set_mask(input logic [1:0] v);
      @(negedge clk);
      mask_we = 1'b1; mask_wdata = v;
      @(negedge clk);
      mask_we = 1'b0;
      m_mask = v;
   endtask

   task automatic clear(input logic [1:0] v);
      @(negedge clk);
      flag_clr = v;
      @(negedge clk);
      flag_clr = 2'b00;
      m_flag = m_flag & ~v;
      m_ovf  = m_ovf & ~v;
   endtask

   task automatic check_idle(input string tag);
      check(snap_master == 0 && snap_slave == 0, tag, snap_master | snap_slave, 0);
      check(evt_flag == 0 && ovf_flag == 0, tag, {evt_flag, ovf_flag}, 0);
      check(mask_q == 0, tag, mask_q, 0);
      check(!irq_master && !irq_slave, tag, {irq_slave, irq_master}, 0);
   endtask

   initial begin
      logic [TW-1:0] hold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 power-on reset");
      quiet = 1'b0;

      // default: capture sets flag only, no interrupt
      pulse(2'b01, 1);
      repeat (6) @(negedge clk);
      check(evt_flag == 2'b01, "R5 flag only", evt_flag, 2'b01);
      check(!irq_master, "R5 irq disabled by default", irq_master, 0);

      pulse(2'b10, 3);
      repeat (6) @(negedge clk);
      check(evt_flag == 2'b11, "R8 both flags", evt_flag, 2'b11);

      set_mask(2'b01);
      check(mask_q == 2'b01, "R6 mask write", mask_q, 2'b01);
      check(irq_master && !irq_slave, "R5 master enabled", {irq_slave, irq_master}, 2'b01);

      // zero bits do nothing, the clear of slave leaves master
      clear(2'b00);
      check(evt_flag == 2'b11, "R4 zero clear ignored", evt_flag, 2'b11);
      clear(2'b10);
      check(evt_flag == 2'b01, "R8 slave clear only", evt_flag, 2'b01);
      check(irq_master, "R8 master irq kept", irq_master, 1);

      // overwrite while pending
      pulse(2'b01, 2);
      repeat (6) @(negedge clk);
      check(ovf_flag == 2'b01, "R7 overflow set", ovf_flag, 2'b01);
      clear(2'b01);
      check(evt_flag == 0 && ovf_flag == 0, "R4 clear flag and overflow",
            {evt_flag, ovf_flag}, 0);
      check(!irq_master, "R5 irq drops on clear", irq_master, 0);

      // long trigger: one capture, falling edge inert
      pulse(2'b10, 12);
      hold = snap_slave;
      repeat (8) @(negedge clk);
      check(snap_slave == hold, "R3 no capture on fall", snap_slave, hold);
      check(ovf_flag[1] == 1'b0, "R3 single capture", ovf_flag[1], 0);
      clear(2'b10);

      // simultaneous captures on both channels
      pulse(2'b11, 1);
      repeat (6) @(negedge clk);
      check(evt_flag == 2'b11, "R8 simultaneous", evt_flag, 2'b11);
      clear(2'b11);

      // capture and clear on the same edge: capture wins
      clear(2'b00);
      @(negedge clk);
      trig_in = 2'b01;
      q.push_back('{ch: 0, t: sys_time + 64'd2, at: cyc + 3});
      @(negedge clk);
      trig_in = 2'b00;
      @(negedge clk);
      flag_clr = 2'b01;
      @(negedge clk);
      flag_clr = 2'b00;
      check(evt_flag[0] == 1'b1, "R9 capture beats clear", evt_flag[0], 1);
      check(ovf_flag[0] == 1'b0, "R9 no overflow from clear flag", ovf_flag[0], 0);
      repeat (2) @(negedge clk);

      // software reset returns to the reset state
      set_mask(2'b11);
      quiet = 1'b1;
      @(negedge clk);
      sw_rst = 1'b1;
      @(negedge clk);
      sw_rst = 1'b0;
      check_idle("R1 software reset");
      m_flag = 0; m_ovf = 0; m_mask = 0;
      @(negedge clk);
      quiet = 1'b0;
      pulse(2'b10, 1);
      repeat (6) @(negedge clk);
      check(evt_flag == 2'b10 && !irq_slave, "R1 enables off after reset",
            {irq_slave, evt_flag}, 3'b010);

      check(q.size() == 0, "R2 missing capture", q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule